// File: doc/BRIEF.md
# Multi-Mode Register Cell Storage

This block is the storage element of one cell in a register-type processing tile. It holds a 16-word by `DATA_W`-bit array. A two-bit mode field selects how the array is used. It can be an addressable register file with separate read and write ports. It can be a variable-length delay line that returns each input word 1 to 16 cycles after it arrived. It can also be a lookup table whose index is taken from the data input. A fourth code parks the block, so that it neither reads nor writes.

When the cell is one of three redundant copies, an external majority voter combines the three read outputs and feeds the result back on `voted_in`. With `tmr_en` high, the block writes that voted word into the location it has just read, one cycle after the read. An upset held in any one copy is therefore cleared the next time the word is used. There is no dual-copy operating mode for this block.

The array has a single write port and a registered read port, so it maps onto a block RAM.

Top module: `mmreg_cell`

## Requirements
- R1: While `rst` is high at a rising edge, `dout` is cleared to 0. It stays 0 after reset until the first read.
- R2: In register-file mode (`mode_sel` = 2'b00), a write with `wr_en` stores `wr_data` at `wr_addr`. A read with `rd_en` samples `rd_addr`, and `dout` shows the word from the following clock edge onward (one cycle of latency).
- R3: In register-file mode, a cycle with `rd_en` low leaves `dout` unchanged.
- R4: A read and a write to the same address at the same edge return the word held before that write.
- R5: In lookup-table mode (`mode_sel` = 2'b10), a read happens every cycle at the address `din[3:0]`. The upper bits of `din` are ignored, and the result appears one edge later. In this mode the table is loaded through the normal write port.
- R6: In delay mode (`mode_sel` = 2'b01), the word on `din` sampled at edge t is on `dout` after edge t+D. D equals `delay_len` for codes 1 to 15, and the code 0 means D = 16.
- R7: In delay mode the write port (`wr_en`, `wr_addr`, `wr_data`) has no effect on the delayed stream.
- R8: With `tmr_en` high, every read in register-file or lookup-table mode is followed, on the next edge, by a write of `voted_in` to the address that was read.
- R9: With `tmr_en` low, `voted_in` has no effect on stored data.
- R10: If a user write is accepted in the cycle when a voted write-back is due, the user write takes the write port and the write-back is dropped.
- R11: In idle mode (`mode_sel` = 2'b11), `dout` holds its value and user writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00 register file, 01 delay line, 10 lookup table, 11 idle |
| tmr_en | input | 1 | Enables voted write-back after reads |
| wr_en | input | 1 | User write strobe |
| wr_addr | input | 4 | User write address |
| wr_data | input | DATA_W | User write data |
| rd_en | input | 1 | Read strobe in register-file mode |
| rd_addr | input | 4 | Read address in register-file mode |
| din | input | DATA_W | Stream input (delay) or lookup index (low 4 bits) |
| delay_len | input | 4 | Delay length code, 0 means 16 |
| voted_in | input | DATA_W | Voted read value from the external voter |
| dout | output | DATA_W | Registered read data |

## Verification
The register-file path is tried with a table of address/data pairs that use distinct, non-repeating values, so a wrong address decode or a swapped latency shows up as a mismatch. Delay mode is streamed with lengths 1, 5 and the code 0. Lengths that are off by one cycle, and a code 0 taken as zero delay, each give a different wrong word. In one stream the write port is also toggled, to show that it is ignored. Lookup mode is driven with indices that have varying upper bits, which separates a 4-bit decode from a full-width one. The write-back tests inject a voted word that differs from the stored one, so the result shows whether the write-back took place, whether it was suppressed, or whether it lost to a user write.

// File: rtl/mmreg_pkg.sv
package mmreg_pkg;
  typedef enum logic [1:0] {
    MD_RFILE = 2'b00,
    MD_DELAY = 2'b01,
    MD_LUT   = 2'b10,
    MD_IDLE  = 2'b11
  } mm_mode_e;
endpackage

// File: rtl/mmreg_store.sv
module mmreg_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single write port, no reset on the array
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // registered read, old data on same-address collision
  always_ff @(posedge clk) begin
    if (rst)     rq <= '0;
    else if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/mmreg_ctrl.sv
module mmreg_ctrl
  import mmreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] delay_len,
  input  logic              wb_pend,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] voted_in,
  output logic              re,
  output logic [ADDR_W-1:0] ra,
  output logic              we,
  output logic [ADDR_W-1:0] wa,
  output logic [DATA_W-1:0] wd,
  output logic [ADDR_W-1:0] wptr
);
  mm_mode_e mode;
  assign mode = mm_mode_e'(mode_sel);

  // circular pointer, advances only while streaming
  always_ff @(posedge clk) begin
    if (rst)                  wptr <= '0;
    else if (mode == MD_DELAY) wptr <= wptr + 1'b1;
  end

  logic              user_we;
  logic [ADDR_W-1:0] tap;

  // wrap of the subtraction makes code 0 a full-depth delay
  assign tap     = wptr - delay_len;
  assign user_we = wr_en && (mode == MD_RFILE || mode == MD_LUT);

  always_comb begin
    re = 1'b0;
    ra = rd_addr;
    unique case (mode)
      MD_RFILE: begin re = rd_en; ra = rd_addr;         end
      MD_LUT:   begin re = 1'b1;  ra = din[ADDR_W-1:0]; end
      MD_DELAY: begin re = 1'b1;  ra = tap;             end
      default:  begin re = 1'b0;  ra = rd_addr;         end
    endcase
  end

  // write port arbitration: stream, then user, then voted write-back
  always_comb begin
    we = 1'b0;
    wa = wr_addr;
    wd = wr_data;
    if (mode == MD_DELAY) begin
      we = 1'b1;
      wa = wptr;
      wd = din;
    end else if (user_we) begin
      we = 1'b1;
      wa = wr_addr;
      wd = wr_data;
    end else if (wb_pend) begin
      we = 1'b1;
      wa = wb_addr;
      wd = voted_in;
    end
  end
endmodule

// File: rtl/mmreg_scrub.sv
module mmreg_scrub
  import mmreg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmr_en,
  input  logic [1:0]        mode_sel,
  input  logic              re,
  input  logic [ADDR_W-1:0] ra,
  output logic              pend,
  output logic [ADDR_W-1:0] pend_addr
);
  // remember the address of each redundant read for one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_addr <= '0;
    end else begin
      pend      <= tmr_en && re && (mm_mode_e'(mode_sel) != MD_DELAY);
      pend_addr <= ra;
    end
  end
endmodule

// File: rtl/mmreg_cell.sv
module mmreg_cell
  import mmreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              tmr_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] delay_len,
  input  logic [DATA_W-1:0] voted_in,
  output logic [DATA_W-1:0] dout
);
  logic              m_re, m_we, wb_pend;
  logic [ADDR_W-1:0] m_ra, m_wa, wb_addr, wptr;
  logic [DATA_W-1:0] m_wd;

  mmreg_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .din(din), .delay_len(delay_len),
    .wb_pend(wb_pend), .wb_addr(wb_addr), .voted_in(voted_in),
    .re(m_re), .ra(m_ra), .we(m_we), .wa(m_wa), .wd(m_wd), .wptr(wptr)
  );

  mmreg_scrub #(.ADDR_W(ADDR_W)) u_scrub (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .mode_sel(mode_sel),
    .re(m_re), .ra(m_ra), .pend(wb_pend), .pend_addr(wb_addr)
  );

  mmreg_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .we(m_we), .wa(m_wa), .wd(m_wd),
    .re(m_re), .ra(m_ra), .rq(dout)
  );
endmodule

// File: rtl/mmreg_cell_chk.sv
module mmreg_cell_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode_sel,
  input logic              tmr_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] voted_in,
  input logic [DATA_W-1:0] dout,
  input logic              wb_pend,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [ADDR_W-1:0] wptr,
  input logic              m_we,
  input logic [ADDR_W-1:0] m_wa,
  input logic [DATA_W-1:0] m_wd
);
  logic user_mode;
  assign user_mode = (mode_sel == 2'b00) || (mode_sel == 2'b10);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00 && !rd_en) |=> $stable(dout));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b11) |=> $stable(dout));

  a_r11_idle_nowrite: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b11 && !wb_pend) |-> !m_we);

  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01) |=> (wptr == ADDR_W'($past(wptr) + 1'b1)));

  a_r8_pend_src: assert property (@(posedge clk) disable iff (rst)
    (tmr_en && mode_sel == 2'b00 && rd_en) |=> (wb_pend && wb_addr == $past(rd_addr)));

  a_r8_writeback: assert property (@(posedge clk) disable iff (rst)
    (wb_pend && !wr_en && user_mode) |-> (m_we && m_wa == wb_addr && m_wd == voted_in));

  a_r9_no_scrub: assert property (@(posedge clk) disable iff (rst)
    (!tmr_en) |=> !wb_pend);

  a_r10_user_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && user_mode) |-> (m_we && m_wa == wr_addr && m_wd == wr_data));
endmodule

bind mmreg_cell mmreg_cell_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .tmr_en(tmr_en),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .voted_in(voted_in), .dout(dout),
  .wb_pend(wb_pend), .wb_addr(wb_addr), .wptr(wptr),
  .m_we(m_we), .m_wa(m_wa), .m_wd(m_wd)
);

// File: tb/mmreg_cell_tb.sv
module mmreg_cell_tb;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam logic [1:0] M_RF = 2'b00, M_DL = 2'b01, M_LT = 2'b10, M_ID = 2'b11;
  // {addr, data} pairs for the register-file table
  localparam logic [11:0] VEC [0:7] = '{12'h0A5, 12'h13C, 12'h2F0, 12'h577,
                                        12'h8E1, 12'hB09, 12'hD6D, 12'hF42};

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst, tmr_en, wr_en, rd_en;
  logic [1:0] mode_sel;
  logic [AW-1:0] wr_addr, rd_addr, delay_len;
  logic [DW-1:0] wr_data, din, voted_in, dout;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  mmreg_cell #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .tmr_en(tmr_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .din(din), .delay_len(delay_len),
    .voted_in(voted_in), .dout(dout)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = dout;
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int s);
    return DW'(i * 37 + s * 11 + 5);
  endfunction

  task automatic run_delay(input logic [AW-1:0] code, input int s, input bit poke);
    int dd;
    dd = (code == 0) ? 16 : int'(code);
    mode_sel = M_DL; delay_len = code;
    for (int i = 0; i < dd + 20; i++) begin
      din = pat(i, s);
      if (poke) begin
        wr_en = i[0]; wr_addr = AW'(i); wr_data = 8'hFF;
      end
      @(negedge clk);
      if (i >= dd) chk(poke ? "R7" : "R6", dout, pat(i - dd, s));
    end
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, hold;
    logic [DW-1:0] tbl [16];
    rst = 1'b1; mode_sel = M_RF; tmr_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; din = '0; delay_len = '0; voted_in = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", dout, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", dout, 8'h00);

    // R2 table-driven write then read back
    for (int k = 0; k < 8; k++) do_wr(VEC[k][11:8], VEC[k][7:0]);
    for (int k = 7; k >= 0; k--) begin
      do_rd(VEC[k][11:8], v);
      chk("R2", v, VEC[k][7:0]);
    end

    // R3 idle read strobe holds
    hold = dout;
    rd_addr = 4'h0;
    repeat (3) begin @(negedge clk); chk("R3", dout, hold); end

    // R4 read-during-write returns old data
    do_wr(4'h9, 8'h44);
    wr_en = 1'b1; wr_addr = 4'h9; wr_data = 8'h88; rd_en = 1'b1; rd_addr = 4'h9;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R4", dout, 8'h44);
    do_rd(4'h9, v);
    chk("R4", v, 8'h88);

    // R8 voted write-back repairs the read word
    tmr_en = 1'b1;
    do_wr(4'h5, 8'h33);
    do_rd(4'h5, v);
    chk("R8", v, 8'h33);
    voted_in = 8'h3C;
    @(negedge clk);
    voted_in = 8'h00; tmr_en = 1'b0;
    do_rd(4'h5, v);
    chk("R8", v, 8'h3C);

    // R10 user write beats a due write-back
    tmr_en = 1'b1;
    do_wr(4'h6, 8'h11);
    do_rd(4'h6, v);
    wr_en = 1'b1; wr_addr = 4'h6; wr_data = 8'h77; voted_in = 8'h99;
    @(negedge clk);
    wr_en = 1'b0; voted_in = 8'h00; tmr_en = 1'b0;
    do_rd(4'h6, v);
    chk("R10", v, 8'h77);

    // R9 voted input ignored without redundancy
    do_wr(4'h7, 8'h21);
    do_rd(4'h7, v);
    voted_in = 8'hEE;
    @(negedge clk);
    voted_in = 8'h00;
    do_rd(4'h7, v);
    chk("R9", v, 8'h21);

    // R11 idle mode holds output and blocks writes
    do_rd(4'h7, v);
    mode_sel = M_ID;
    for (int k = 0; k < 3; k++) begin
      wr_en = 1'b1; wr_addr = 4'h7; wr_data = 8'hC3; rd_en = 1'b1; rd_addr = 4'h2;
      din = DW'(k);
      @(negedge clk);
      chk("R11", dout, 8'h21);
    end
    wr_en = 1'b0; rd_en = 1'b0; mode_sel = M_RF;
    do_rd(4'h7, v);
    chk("R11", v, 8'h21);

    // R5 table loaded in lookup mode, indexed by low input bits
    mode_sel = M_LT;
    for (int k = 0; k < 16; k++) begin
      tbl[k] = DW'(k * k + 3);
      do_wr(AW'(k), tbl[k]);
    end
    for (int k = 0; k < 24; k++) begin
      din = DW'(k * 29 + 7);
      @(negedge clk);
      chk("R5", dout, tbl[(k * 29 + 7) % 16]);
    end

    // R6 / R7 delay line
    run_delay(4'd1, 1, 1'b0);
    run_delay(4'd5, 2, 1'b1);
    run_delay(4'd0, 3, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule